// File: doc/BRIEF.md
# Dual Data Pointer and External-Data Address Unit

This unit lives inside an 8051-class processor core. It holds two 16-bit data pointers, a one-bit pointer select register and an 8-bit page register. From these it forms the 16-bit address for external data moves. The address has two forms. In the pointer form, the whole address comes from whichever pointer is currently selected. In the register-indirect form, the page register supplies the upper byte and the core's Ri value supplies the lower byte.

The core reaches all six byte-wide registers over a simple SFR bus. Reads are combinational and writes take effect at the next clock edge. Separate strobes from the instruction decoder do three things: increment the selected pointer, decrement it, or flip the select bit. The unit also reports whether the current address falls inside the on-chip external RAM window. That window starts at address 0 and is `RAM_BYTES` long, 384 bytes by default.

Top module: `xaddr_unit`

## Requirements
- R1: After reset, both pointers, the page register and the select register are 0. Every owned SFR reads 00h, and in the pointer form the address is 0000h.
- R2: The SFR map is: pointer 0 low byte at 82h, pointer 0 high byte at 83h, pointer 1 low byte at 84h, pointer 1 high byte at 85h, select at 86h, page at B2h. `sfrHit` is 1 only for these six addresses. `sfrRdData` is 00h for any other address.
- R3: The select register stores only bit 0 of a write. Bits 7..1 always read back as 0.
- R4: A `selToggle` pulse flips the select bit, and its upper bits stay 0.
- R5: `ptrInc` adds 1 to the selected 16-bit pointer modulo 2^16, with the carry passing from the low byte to the high byte. The other pointer is unchanged.
- R6: `ptrDec` subtracts 1 from the selected pointer modulo 2^16, with the borrow passing between the bytes. If `ptrInc` and `ptrDec` are both high, the increment is performed.
- R7: With `movxRi` = 0, `xAddr` equals the pointer chosen by the select bit: 0 chooses pointer 0 and 1 chooses pointer 1.
- R8: With `movxRi` = 1, `xAddr[15:8]` is the page register and `xAddr[7:0]` is `riValue`.
- R9: `xOnChip` is 1 exactly when `xAddr` is below 0180h. For the default `RAM_BYTES` of 384, this means 017Fh hits and 0180h misses.
- R10: An SFR write to either byte of the selected pointer in the same cycle as an increment or decrement takes priority. The written byte takes the new value, the other byte holds its old value, and the step is dropped. An SFR write to the select register in the same cycle as `selToggle` also takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| sfrAddr | input | 8 | SFR address for read and write |
| sfrWrEn | input | 1 | SFR write strobe |
| sfrWrData | input | 8 | SFR write data |
| sfrRdData | output | 8 | Read data of the addressed register, 00h when not owned |
| sfrHit | output | 1 | Address belongs to this unit |
| ptrInc | input | 1 | Increment the selected pointer |
| ptrDec | input | 1 | Decrement the selected pointer |
| selToggle | input | 1 | Flip the pointer select bit |
| riValue | input | 8 | Ri register value from the core |
| movxRi | input | 1 | 1 = register-indirect address form, 0 = pointer form |
| xAddr | output | 16 | External data address |
| xOnChip | output | 1 | Address lies in the on-chip external RAM |

## Verification
The pointers are loaded with patterns chosen so that a bug in one spot cannot hide behind another. Distinct bytes in each pointer expose a byte or pointer swap in the read path and in the pointer form of the address. Values such as FFFFh, 00FFh, 0100h and 0000h make the carry and borrow cross the byte boundary and wrap. A simultaneous write and step tell apart whether the write wins or the two merge. Page and Ri values around 017Fh/0180h, together with a high page, separate a correct window compare from one that looks only at the low byte.

// File: rtl/xaddr_pkg.sv
package xaddr_pkg;
  localparam int NUM_PTR = 2;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 2 * BYTE_W;
  localparam int IDX_W   = $clog2(NUM_PTR);

  localparam logic [BYTE_W-1:0] PTR0_LO_ADR = 8'h82;
  localparam logic [BYTE_W-1:0] PTR0_HI_ADR = 8'h83;
  localparam logic [BYTE_W-1:0] PTR1_LO_ADR = 8'h84;
  localparam logic [BYTE_W-1:0] PTR1_HI_ADR = 8'h85;
  localparam logic [BYTE_W-1:0] SEL_ADR     = 8'h86;
  localparam logic [BYTE_W-1:0] PAGE_ADR    = 8'hB2;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_LO,
    RD_HI,
    RD_SEL,
    RD_PAGE
  } rd_src_e;

  typedef struct packed {
    logic [NUM_PTR-1:0] wrLo;
    logic [NUM_PTR-1:0] wrHi;
    logic [NUM_PTR-1:0] step;
    logic               stepDown;
    logic               wrSel;
    logic               togSel;
    logic               wrPage;
    rd_src_e            rdSrc;
    logic [IDX_W-1:0]   rdIdx;
  } strobe_t;
endpackage

// File: rtl/xaddr_ctrl.sv
module xaddr_ctrl
  import xaddr_pkg::*;
(
  input  logic [BYTE_W-1:0] sfrAddr,
  input  logic              sfrWrEn,
  input  logic              ptrInc,
  input  logic              ptrDec,
  input  logic              selToggle,
  input  logic [IDX_W-1:0]  selQ,
  output strobe_t           stb,
  output logic              sfrHit
);
  logic [NUM_PTR-1:0] loHit;
  logic [NUM_PTR-1:0] hiHit;
  logic [NUM_PTR-1:0] wrLoV;
  logic [NUM_PTR-1:0] wrHiV;
  logic [NUM_PTR-1:0] stepV;
  logic               selHit;
  logic               pageHit;

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptrDec
    localparam logic [BYTE_W-1:0] LO_ADR = (i == 0) ? PTR0_LO_ADR : PTR1_LO_ADR;
    localparam logic [BYTE_W-1:0] HI_ADR = (i == 0) ? PTR0_HI_ADR : PTR1_HI_ADR;
    assign loHit[i] = (sfrAddr == LO_ADR);
    assign hiHit[i] = (sfrAddr == HI_ADR);
    assign wrLoV[i] = sfrWrEn && loHit[i];
    assign wrHiV[i] = sfrWrEn && hiHit[i];
    // a write to either byte of the pointer blocks its step
    assign stepV[i] = (ptrInc || ptrDec) && (selQ == IDX_W'(i))
                      && !(wrLoV[i] || wrHiV[i]);
  end

  assign selHit  = (sfrAddr == SEL_ADR);
  assign pageHit = (sfrAddr == PAGE_ADR);
  assign sfrHit  = (|loHit) || (|hiHit) || selHit || pageHit;

  always_comb begin
    stb          = '0;
    stb.wrLo     = wrLoV;
    stb.wrHi     = wrHiV;
    stb.step     = stepV;
    stb.stepDown = !ptrInc;
    stb.wrSel    = sfrWrEn && selHit;
    stb.togSel   = selToggle && !(sfrWrEn && selHit);
    stb.wrPage   = sfrWrEn && pageHit;
    stb.rdSrc    = RD_NONE;
    stb.rdIdx    = '0;
    for (int i = 0; i < NUM_PTR; i++) begin
      if (loHit[i]) begin
        stb.rdSrc = RD_LO;
        stb.rdIdx = IDX_W'(i);
      end
      if (hiHit[i]) begin
        stb.rdSrc = RD_HI;
        stb.rdIdx = IDX_W'(i);
      end
    end
    if (selHit)  stb.rdSrc = RD_SEL;
    if (pageHit) stb.rdSrc = RD_PAGE;
  end
endmodule

// File: rtl/xaddr_path.sv
module xaddr_path
  import xaddr_pkg::*;
#(
  parameter int RAM_BYTES = 384
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [BYTE_W-1:0] sfrWrData,
  input  logic [BYTE_W-1:0] riValue,
  input  logic              movxRi,
  output logic [IDX_W-1:0]  selQ,
  output logic [BYTE_W-1:0] sfrRdData,
  output logic [ADDR_W-1:0] xAddr,
  output logic              xOnChip
);
  localparam logic [ADDR_W:0] RAM_LIMIT = (ADDR_W + 1)'(RAM_BYTES);

  logic [ADDR_W-1:0] ptrQ [NUM_PTR];
  logic [BYTE_W-1:0] pageQ;
  logic [ADDR_W-1:0] selPtr;
  logic [ADDR_W-1:0] stepVal;

  // one shared incrementer/decrementer serves the selected pointer
  assign selPtr  = ptrQ[selQ];
  assign stepVal = stb.stepDown ? selPtr - ADDR_W'(1) : selPtr + ADDR_W'(1);

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ptrQ[i] <= '0;
      end else if (stb.wrLo[i] || stb.wrHi[i]) begin
        if (stb.wrLo[i]) ptrQ[i][BYTE_W-1:0]      <= sfrWrData;
        if (stb.wrHi[i]) ptrQ[i][ADDR_W-1:BYTE_W] <= sfrWrData;
      end else if (stb.step[i]) begin
        ptrQ[i] <= stepVal;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ  <= '0;
      pageQ <= '0;
    end else begin
      if (stb.wrSel)       selQ <= sfrWrData[IDX_W-1:0];
      else if (stb.togSel) selQ <= selQ + IDX_W'(1);
      if (stb.wrPage)      pageQ <= sfrWrData;
    end
  end

  always_comb begin
    unique case (stb.rdSrc)
      RD_LO:   sfrRdData = ptrQ[stb.rdIdx][BYTE_W-1:0];
      RD_HI:   sfrRdData = ptrQ[stb.rdIdx][ADDR_W-1:BYTE_W];
      RD_SEL:  sfrRdData = BYTE_W'(selQ);
      RD_PAGE: sfrRdData = pageQ;
      default: sfrRdData = '0;
    endcase
  end

  assign xAddr   = movxRi ? {pageQ, riValue} : selPtr;
  assign xOnChip = ({1'b0, xAddr} < RAM_LIMIT);
endmodule

// File: rtl/xaddr_unit.sv
module xaddr_unit
  import xaddr_pkg::*;
#(
  parameter int RAM_BYTES = 384
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  sfrAddr,
  input  logic        sfrWrEn,
  input  logic [7:0]  sfrWrData,
  output logic [7:0]  sfrRdData,
  output logic        sfrHit,
  input  logic        ptrInc,
  input  logic        ptrDec,
  input  logic        selToggle,
  input  logic [7:0]  riValue,
  input  logic        movxRi,
  output logic [15:0] xAddr,
  output logic        xOnChip
);
  strobe_t          stb;
  logic [IDX_W-1:0] selQ;

  xaddr_ctrl u_ctrl (
    .sfrAddr   (sfrAddr),
    .sfrWrEn   (sfrWrEn),
    .ptrInc    (ptrInc),
    .ptrDec    (ptrDec),
    .selToggle (selToggle),
    .selQ      (selQ),
    .stb       (stb),
    .sfrHit    (sfrHit)
  );

  xaddr_path #(.RAM_BYTES(RAM_BYTES)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .sfrWrData (sfrWrData),
    .riValue   (riValue),
    .movxRi    (movxRi),
    .selQ      (selQ),
    .sfrRdData (sfrRdData),
    .xAddr     (xAddr),
    .xOnChip   (xOnChip)
  );
endmodule

// File: rtl/xaddr_unit_chk.sv
module xaddr_unit_chk (
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  sfrAddr,
  input logic        sfrWrEn,
  input logic [7:0]  sfrRdData,
  input logic        ptrInc,
  input logic        ptrDec,
  input logic        selToggle,
  input logic [7:0]  riValue,
  input logic        movxRi,
  input logic [15:0] xAddr,
  input logic        xOnChip,
  input logic        selQ
);
  assert_sel_upper_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sfrAddr == 8'h86) |-> (sfrRdData[7:1] == 7'd0));

  assert_toggle_flips_R4: assert property (@(posedge clk) disable iff (!rstN)
    (selToggle && !sfrWrEn) |=> (selQ != $past(selQ)));

  assert_inc_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!movxRi && ptrInc && !sfrWrEn && !selToggle)
      |=> (movxRi || xAddr == $past(xAddr) + 16'd1));

  assert_dec_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!movxRi && ptrDec && !ptrInc && !sfrWrEn && !selToggle)
      |=> (movxRi || xAddr == $past(xAddr) - 16'd1));

  assert_ri_low_byte_R8: assert property (@(posedge clk) disable iff (!rstN)
    movxRi |-> (xAddr[7:0] == riValue));

  assert_far_miss_R9: assert property (@(posedge clk) disable iff (!rstN)
    (xAddr[15:9] != 7'd0) |-> !xOnChip);
endmodule

bind xaddr_unit xaddr_unit_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .sfrAddr   (sfrAddr),
  .sfrWrEn   (sfrWrEn),
  .sfrRdData (sfrRdData),
  .ptrInc    (ptrInc),
  .ptrDec    (ptrDec),
  .selToggle (selToggle),
  .riValue   (riValue),
  .movxRi    (movxRi),
  .xAddr     (xAddr),
  .xOnChip   (xOnChip),
  .selQ      (selQ)
);

// File: tb/xaddr_unit_bench.sv
module xaddr_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  sfrAddr = 8'h00;
  logic        sfrWrEn = 1'b0;
  logic [7:0]  sfrWrData = 8'h00;
  logic [7:0]  sfrRdData;
  logic        sfrHit;
  logic        ptrInc = 1'b0;
  logic        ptrDec = 1'b0;
  logic        selToggle = 1'b0;
  logic [7:0]  riValue = 8'h00;
  logic        movxRi = 1'b0;
  logic [15:0] xAddr;
  logic        xOnChip;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  xaddr_unit u_xaddr_unit (
    .clk(clk), .rstN(rstN), .sfrAddr(sfrAddr), .sfrWrEn(sfrWrEn),
    .sfrWrData(sfrWrData), .sfrRdData(sfrRdData), .sfrHit(sfrHit),
    .ptrInc(ptrInc), .ptrDec(ptrDec), .selToggle(selToggle),
    .riValue(riValue), .movxRi(movxRi), .xAddr(xAddr), .xOnChip(xOnChip)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    sfrAddr = a;
    #1;
    d = sfrRdData;
  endtask

  // one-cycle operation: strobes set after a falling edge, cleared after the next
  task automatic op(input logic we, input logic [7:0] a, input logic [7:0] d,
                    input logic inc, input logic dec, input logic tog);
    @(negedge clk);
    sfrAddr = a; sfrWrData = d; sfrWrEn = we;
    ptrInc = inc; ptrDec = dec; selToggle = tog;
    @(negedge clk);
    sfrWrEn = 1'b0; ptrInc = 1'b0; ptrDec = 1'b0; selToggle = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    op(1'b1, a, d, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic ptrAddr(output logic [15:0] v);
    movxRi = 1'b0;
    #1;
    v = xAddr;
  endtask

  task automatic testReset();
    logic [7:0] d;
    logic [15:0] a;
    rd(8'h82, d); chk("R1 ptr0 lo", {8'h0, d}, 16'h0000);
    rd(8'h83, d); chk("R1 ptr0 hi", {8'h0, d}, 16'h0000);
    rd(8'h84, d); chk("R1 ptr1 lo", {8'h0, d}, 16'h0000);
    rd(8'h85, d); chk("R1 ptr1 hi", {8'h0, d}, 16'h0000);
    rd(8'h86, d); chk("R1 select", {8'h0, d}, 16'h0000);
    rd(8'hB2, d); chk("R1 page", {8'h0, d}, 16'h0000);
    ptrAddr(a);   chk("R1 address", a, 16'h0000);
  endtask

  task automatic testMap();
    logic [7:0] d;
    wr(8'h82, 8'h12); wr(8'h83, 8'h34); wr(8'h84, 8'h56);
    wr(8'h85, 8'h78); wr(8'hB2, 8'h9A);
    rd(8'h82, d); chk("R2 ptr0 lo", {8'h0, d}, 16'h0012);
    rd(8'h83, d); chk("R2 ptr0 hi", {8'h0, d}, 16'h0034);
    rd(8'h84, d); chk("R2 ptr1 lo", {8'h0, d}, 16'h0056);
    rd(8'h85, d); chk("R2 ptr1 hi", {8'h0, d}, 16'h0078);
    rd(8'hB2, d); chk("R2 page", {8'h0, d}, 16'h009A);
    chk("R2 hit owned", {15'h0, sfrHit}, 16'h0001);
    rd(8'h80, d); chk("R2 foreign read", {8'h0, d}, 16'h0000);
    chk("R2 hit foreign", {15'h0, sfrHit}, 16'h0000);
    wr(8'h86, 8'hFF);
    rd(8'h86, d); chk("R3 select reads 01", {8'h0, d}, 16'h0001);
    wr(8'h86, 8'hFE);
    rd(8'h86, d); chk("R3 only bit 0 kept", {8'h0, d}, 16'h0000);
  endtask

  task automatic testSelect();
    logic [15:0] a;
    logic [7:0] d;
    ptrAddr(a); chk("R7 select 0 form", a, 16'h3412);
    op(1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1);
    rd(8'h86, d); chk("R4 toggle to 1", {8'h0, d}, 16'h0001);
    ptrAddr(a); chk("R7 select 1 form", a, 16'h7856);
    op(1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1);
    rd(8'h86, d); chk("R4 toggle back to 0", {8'h0, d}, 16'h0000);
  endtask

  task automatic testInc();
    logic [15:0] a;
    logic [7:0] d;
    wr(8'h82, 8'hFF); wr(8'h83, 8'hFF);
    op(1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0);
    ptrAddr(a); chk("R5 wrap FFFF+1", a, 16'h0000);
    wr(8'h82, 8'hFF); wr(8'h83, 8'h00);
    op(1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0);
    ptrAddr(a); chk("R5 carry 00FF+1", a, 16'h0100);
    rd(8'h84, d); chk("R5 other ptr lo kept", {8'h0, d}, 16'h0056);
    rd(8'h85, d); chk("R5 other ptr hi kept", {8'h0, d}, 16'h0078);
  endtask

  task automatic testDec();
    logic [15:0] a;
    logic [7:0] d;
    op(1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
    ptrAddr(a); chk("R6 borrow 0100-1", a, 16'h00FF);
    wr(8'h82, 8'h00); wr(8'h83, 8'h00);
    op(1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
    ptrAddr(a); chk("R6 wrap 0000-1", a, 16'hFFFF);
    wr(8'h86, 8'h01);
    op(1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
    ptrAddr(a); chk("R6 dec on ptr1", a, 16'h7855);
    rd(8'h83, d); chk("R6 ptr0 untouched", {8'h0, d}, 16'h00FF);
    op(1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0);
    ptrAddr(a); chk("R6 inc wins over dec", a, 16'h7856);
    wr(8'h86, 8'h00);
  endtask

  task automatic testRi();
    wr(8'hB2, 8'h9A);
    movxRi = 1'b1; riValue = 8'h34; #1;
    chk("R8 page and Ri", xAddr, 16'h9A34);
    chk("R9 high page misses", {15'h0, xOnChip}, 16'h0000);
    wr(8'hB2, 8'h01);
    movxRi = 1'b1; riValue = 8'h7F; #1;
    chk("R9 017F hits", {15'h0, xOnChip}, 16'h0001);
    riValue = 8'h80; #1;
    chk("R9 0180 misses", {15'h0, xOnChip}, 16'h0000);
    chk("R8 Ri 80", xAddr, 16'h0180);
    wr(8'hB2, 8'h00);
    movxRi = 1'b1; riValue = 8'hFF; #1;
    chk("R9 00FF hits", {15'h0, xOnChip}, 16'h0001);
    movxRi = 1'b0;
  endtask

  task automatic testPriority();
    logic [15:0] a;
    logic [7:0] d;
    wr(8'h82, 8'h34); wr(8'h83, 8'h12);
    op(1'b1, 8'h82, 8'hAA, 1'b1, 1'b0, 1'b0);
    ptrAddr(a); chk("R10 write beats inc", a, 16'h12AA);
    op(1'b1, 8'h83, 8'h55, 1'b0, 1'b1, 1'b0);
    ptrAddr(a); chk("R10 write beats dec", a, 16'h55AA);
    op(1'b1, 8'h84, 8'h11, 1'b1, 1'b0, 1'b0);
    ptrAddr(a); chk("R10 other ptr write, step kept", a, 16'h55AB);
    rd(8'h84, d); chk("R10 other ptr written", {8'h0, d}, 16'h0011);
    op(1'b1, 8'h86, 8'h00, 1'b0, 1'b0, 1'b1);
    rd(8'h86, d); chk("R10 select write beats toggle", {8'h0, d}, 16'h0000);
    ptrAddr(a); chk("R9 017F window via pointer", {15'h0, xOnChip}, 16'h0000);
    wr(8'h82, 8'h7F); wr(8'h83, 8'h01);
    ptrAddr(a); chk("R9 pointer 017F hits", {15'h0, xOnChip}, 16'h0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testMap();
    testSelect();
    testInc();
    testDec();
    testRi();
    testPriority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule